// File: doc/BRIEF.md
# Addressed Peripheral Register Slave

This block connects one external device to a shared 16-bit address/data bus. It owns a 16-word slot inside the upper address window (0xF000 to 0xFFFF), chosen by a base-address parameter. An access whose upper twelve address bits equal those of the base hits the block. The low four bits then pick a register: a data port, a control word and a status word. The data port is two registers in one slot. A bus write fills the outbound register, which the device reads. A bus read returns the inbound register, which the device fills.

The block also asks the bus arbiter for service when the device has new inbound data and software has set the run bit. After the arbiter grants access, the block puts its own base address on the data lines for one cycle so the master can tell which function asked. The bus is modelled as synchronous read and write strobes, one direction at a time. The device is modelled by a ready level, an error pulse and a data-valid strobe.

Top module: `periphSlave`

## Requirements
- R1: Only an address whose bits 15..4 equal those of `BASE_ADDR` is accepted. Any other address leaves `busOe` low, leaves `busDataOut` at zero and changes no register.
- R2: A write to offset 0x0 loads the outbound register. In the next cycle `devOutData` shows the written value and `devOutStrobe` is high for exactly one cycle.
- R3: A high `devInValid` captures `devInData` into the inbound register and sets the pending flag. A read of offset 0x0 returns the inbound register and clears pending. If a capture and that read fall in the same cycle, pending stays set.
- R4: Offset 0x1 is the control register. Writes replace all 16 bits, reads return it, and bit 0 is the run bit.
- R5: A read of offset 0x2 returns the status word. Bit 0 is `devReady`, bit 1 is the run bit (function ready), bit 15 is the error flag, and all other bits are 0.
- R6: The error flag is set in the cycle after `devError` is high. It stays set until a status write, and a `devError` in the same cycle as that write keeps it set.
- R7: A status write (offset 0x2, data ignored) clears the control register, the pending flag and the request sequence. The inbound and outbound data registers are kept.
- R8: Reads of offsets 0x3 to 0xF drive `busOe` high with data zero.
- R9: `svcReq` rises in the cycle after run and pending are both seen high. It falls back, without a grant, in the cycle after run is seen low.
- R10: While `svcReq` is high, a `svcGrant` starts the identifier cycle in the next cycle. In that cycle `svcReq` stays high, `busOe` is high, `busDataOut` equals `BASE_ADDR`, and any bus read is ignored. `svcReq` is low in the cycle after.
- R11: After the identifier cycle, no new request is made until the pending flag has been cleared.
- R12: After reset all registers are zero and `svcReq`, `busOe` and `devOutStrobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | Bus address |
| busWrEn | input | 1 | Write strobe for this cycle |
| busRdEn | input | 1 | Read strobe for this cycle |
| busWrData | input | 16 | Write data |
| busDataOut | output | 16 | Read data or identifier, zero when not driving |
| busOe | output | 1 | Block drives the data lines |
| svcReq | output | 1 | Service request to the arbiter |
| svcGrant | input | 1 | Grant from the arbiter |
| devInData | input | 16 | Data from the device |
| devInValid | input | 1 | Capture strobe for devInData |
| devOutData | output | 16 | Outbound register toward the device |
| devOutStrobe | output | 1 | One-cycle pulse after an outbound write |
| devReady | input | 1 | Device ready level |
| devError | input | 1 | Device error pulse |

## Verification
The assertions assume the bus never raises read and write together. They also assume the arbiter raises `svcGrant` only while `svcReq` is high, and that no master reads the block during its identifier cycle. The stimulus drives one bus strobe per cycle and raises the grant only while the request is visible. The only read it issues during an identifier cycle is a deliberate one, used to check that the identifier wins.

// File: rtl/periphPkg.sv
package periphPkg;

  typedef struct packed {
    logic wrOut;
    logic wrCtrl;
    logic fnClear;
    logic rdIn;
    logic rdCtrl;
    logic rdStat;
    logic rdZero;
    logic idDrive;
  } strobeT;

  typedef enum logic [1:0] {
    REQ_IDLE = 2'd0,
    REQ_ASK  = 2'd1,
    REQ_ID   = 2'd2,
    REQ_HOLD = 2'd3
  } reqStateT;

endpackage

// File: rtl/periphCtrl.sv
module periphCtrl
  import periphPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF520
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              svcGrant,
  input  logic              runBit,
  input  logic              pending,
  output strobeT            strb,
  output logic              svcReq
);

  localparam logic [OFF_W-1:0] OFF_DATA = OFF_W'(0);
  localparam logic [OFF_W-1:0] OFF_CTRL = OFF_W'(1);
  localparam logic [OFF_W-1:0] OFF_STAT = OFF_W'(2);

  reqStateT reqState, reqNext;
  logic hit;
  logic [OFF_W-1:0] off;
  logic rdOk;

  assign hit  = (busAddr[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W]);
  assign off  = busAddr[OFF_W-1:0];
  assign rdOk = busRdEn && hit && (reqState != REQ_ID);

  always_comb begin
    strb.wrOut   = busWrEn && hit && (off == OFF_DATA);
    strb.wrCtrl  = busWrEn && hit && (off == OFF_CTRL);
    strb.fnClear = busWrEn && hit && (off == OFF_STAT);
    strb.rdIn    = rdOk && (off == OFF_DATA);
    strb.rdCtrl  = rdOk && (off == OFF_CTRL);
    strb.rdStat  = rdOk && (off == OFF_STAT);
    strb.rdZero  = rdOk && (off > OFF_STAT);
    strb.idDrive = (reqState == REQ_ID);
  end

  assign svcReq = (reqState == REQ_ASK) || (reqState == REQ_ID);

  always_comb begin
    reqNext = reqState;
    if (strb.fnClear) begin
      reqNext = REQ_IDLE;
    end else begin
      case (reqState)
        REQ_IDLE: if (runBit && pending) reqNext = REQ_ASK;
        REQ_ASK: begin
          if (svcGrant)     reqNext = REQ_ID;
          else if (!runBit) reqNext = REQ_IDLE;
        end
        REQ_ID:   reqNext = REQ_HOLD;
        REQ_HOLD: if (!pending) reqNext = REQ_IDLE;
        default:  reqNext = REQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqState <= REQ_IDLE;
    else       reqState <= reqNext;
  end

  // R10
  id_after_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqState == REQ_ASK && svcGrant && !strb.fnClear) |=> strb.idDrive);

  // R10
  req_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.idDrive |=> !svcReq);

  // R9
  req_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(svcReq) |-> $past(runBit && pending));

  // R11
  no_rerequest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqState == REQ_HOLD && pending) |=> !svcReq);

endmodule

// File: rtl/periphData.sv
module periphData
  import periphPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF520
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] devInData,
  input  logic              devInValid,
  input  logic              devReady,
  input  logic              devError,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busOe,
  output logic [DATA_W-1:0] devOutData,
  output logic              devOutStrobe,
  output logic              runBit,
  output logic              pending
);

  localparam int PAD_W = DATA_W - 3;

  logic [DATA_W-1:0] inReg, outReg, ctrlReg, statusWord;
  logic errFlag, pendFlag, outStb;

  assign statusWord = {errFlag, {PAD_W{1'b0}}, ctrlReg[0], devReady};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inReg    <= '0;
      outReg   <= '0;
      ctrlReg  <= '0;
      errFlag  <= 1'b0;
      pendFlag <= 1'b0;
      outStb   <= 1'b0;
    end else begin
      outStb <= strb.wrOut;
      if (strb.wrOut) outReg <= busWrData;
      if (strb.fnClear)     ctrlReg <= '0;
      else if (strb.wrCtrl) ctrlReg <= busWrData;
      if (devInValid) begin
        inReg    <= devInData;
        pendFlag <= 1'b1;
      end else if (strb.fnClear || strb.rdIn) begin
        pendFlag <= 1'b0;
      end
      if (devError)          errFlag <= 1'b1;
      else if (strb.fnClear) errFlag <= 1'b0;
    end
  end

  always_comb begin
    busDataOut = '0;
    if (strb.idDrive)     busDataOut = DATA_W'(BASE_ADDR);
    else if (strb.rdIn)   busDataOut = inReg;
    else if (strb.rdCtrl) busDataOut = ctrlReg;
    else if (strb.rdStat) busDataOut = statusWord;
  end

  assign busOe        = strb.idDrive | strb.rdIn | strb.rdCtrl | strb.rdStat | strb.rdZero;
  assign devOutData   = outReg;
  assign devOutStrobe = outStb;
  assign runBit       = ctrlReg[0];
  assign pending      = pendFlag;

  // R7
  clear_ctrl_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fnClear |=> (ctrlReg == '0));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !strb.fnClear) |=> errFlag);

  // R3
  capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    devInValid |=> (pendFlag && inReg == $past(devInData)));

  // R2
  out_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrOut |=> (devOutStrobe && devOutData == $past(busWrData)));

endmodule

// File: rtl/periphSlave.sv
module periphSlave
  import periphPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int OFF_W  = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF520
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busOe,
  output logic              svcReq,
  input  logic              svcGrant,
  input  logic [DATA_W-1:0] devInData,
  input  logic              devInValid,
  output logic [DATA_W-1:0] devOutData,
  output logic              devOutStrobe,
  input  logic              devReady,
  input  logic              devError
);

  strobeT strb;
  logic runBit, pending;

  periphCtrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BASE_ADDR(BASE_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .svcGrant(svcGrant), .runBit(runBit),
    .pending(pending), .strb(strb), .svcReq(svcReq)
  );

  periphData #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .busWrData(busWrData),
    .devInData(devInData), .devInValid(devInValid), .devReady(devReady),
    .devError(devError), .busDataOut(busDataOut), .busOe(busOe),
    .devOutData(devOutData), .devOutStrobe(devOutStrobe),
    .runBit(runBit), .pending(pending)
  );

  // R1
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[ADDR_W-1:OFF_W] != BASE_ADDR[ADDR_W-1:OFF_W] && !strb.idDrive) |-> !busOe);

endmodule

// File: tb/tb_periphSlave.sv
module tb_periphSlave;

  localparam logic [15:0] BASE = 16'hF520;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] busAddr = '0, busWrData = '0, devInData = '0;
  logic busWrEn = 0, busRdEn = 0, svcGrant = 0, devInValid = 0, devReady = 0, devError = 0;
  logic [15:0] busDataOut, devOutData;
  logic busOe, svcReq, devOutStrobe;

  int compared = 0;
  int mismatched = 0;

  // reference model state
  logic [15:0] mCtrl = 0, mIn = 0, mOut = 0;
  logic mPend = 0, mErr = 0, mOutStb = 0;
  int mSt = 0;

  always #5 clk = ~clk;

  periphSlave dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busDataOut(busDataOut),
    .busOe(busOe), .svcReq(svcReq), .svcGrant(svcGrant),
    .devInData(devInData), .devInValid(devInValid), .devOutData(devOutData),
    .devOutStrobe(devOutStrobe), .devReady(devReady), .devError(devError)
  );

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic tick(string tag);
    logic hit, id, rdEff, clr;
    logic [3:0] off;
    logic [15:0] expData;
    int nSt;
    #4;
    hit   = (busAddr[15:4] == BASE[15:4]);
    off   = busAddr[3:0];
    id    = (mSt == 2);
    rdEff = busRdEn && hit && !id;
    expData = 16'h0;
    if (id) expData = BASE;
    else if (rdEff) begin
      if (off == 0)      expData = mIn;
      else if (off == 1) expData = mCtrl;
      else if (off == 2) expData = {mErr, 13'b0, mCtrl[0], devReady};
    end
    check(tag, "busOe", 16'(busOe), 16'(id || rdEff));
    check(tag, "busDataOut", busDataOut, expData);
    check(tag, "svcReq", 16'(svcReq), 16'(mSt == 1 || mSt == 2));
    check(tag, "devOutData", devOutData, mOut);
    check(tag, "devOutStrobe", 16'(devOutStrobe), 16'(mOutStb));
    @(posedge clk);
    clr = busWrEn && hit && off == 2;
    nSt = mSt;
    if (clr) nSt = 0;
    else if (mSt == 0) begin if (mCtrl[0] && mPend) nSt = 1; end
    else if (mSt == 1) begin if (svcGrant) nSt = 2; else if (!mCtrl[0]) nSt = 0; end
    else if (mSt == 2) nSt = 3;
    else if (!mPend) nSt = 0;
    mSt = nSt;
    mOutStb = busWrEn && hit && off == 0;
    if (mOutStb) mOut = busWrData;
    if (clr) mCtrl = 0;
    else if (busWrEn && hit && off == 1) mCtrl = busWrData;
    if (devInValid) begin mIn = devInData; mPend = 1; end
    else if (clr || (rdEff && off == 0)) mPend = 0;
    if (devError) mErr = 1;
    else if (clr) mErr = 0;
    @(negedge clk);
  endtask

  task automatic wrBus(logic [15:0] a, logic [15:0] d, string tag);
    busAddr = a; busWrData = d; busWrEn = 1;
    tick(tag);
    busWrEn = 0;
  endtask

  task automatic rdBus(logic [15:0] a, string tag);
    busAddr = a; busRdEn = 1;
    tick(tag);
    busRdEn = 0;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic feed(logic [15:0] d, string tag);
    devInData = d; devInValid = 1;
    tick(tag);
    devInValid = 0;
  endtask

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    idle(2, "R12");
    rdBus(BASE + 16'h1, "R12");
    rdBus(BASE + 16'h2, "R12");
    // control register
    wrBus(BASE + 16'h1, 16'h1234, "R4");
    rdBus(BASE + 16'h1, "R4");
    // outbound
    wrBus(BASE, 16'h5A5A, "R2");
    idle(2, "R2");
    wrBus(BASE, 16'hA5A5, "R2");
    wrBus(BASE, 16'h0F0F, "R2");
    idle(1, "R2");
    // address miss
    wrBus(16'hF530 | 16'h1, 16'hFFFF, "R1");
    wrBus(16'h0521, 16'hFFFF, "R1");
    wrBus(16'hF522 ^ 16'h0100, 16'h0, "R1");
    rdBus(16'hF430, "R1");
    rdBus(16'h0520, "R1");
    rdBus(BASE + 16'h1, "R1");
    // unused offsets
    for (int k = 3; k < 16; k += 4) rdBus(BASE + 16'(k), "R8");
    rdBus(BASE + 16'hF, "R8");
    // status and sticky error
    devReady = 1;
    rdBus(BASE + 16'h2, "R5");
    devError = 1; tick("R6"); devError = 0;
    idle(2, "R6");
    rdBus(BASE + 16'h2, "R6");
    devReady = 0;
    rdBus(BASE + 16'h2, "R5");
    // inbound capture with run off: no request
    feed(16'hC0DE, "R3");
    idle(2, "R3");
    rdBus(BASE, "R3");
    rdBus(BASE, "R3");
    // capture and read in same cycle
    feed(16'h1111, "R3");
    busAddr = BASE; busRdEn = 1; devInData = 16'h2222; devInValid = 1;
    tick("R3");
    busRdEn = 0; devInValid = 0;
    rdBus(BASE, "R3");
    // request sequence
    wrBus(BASE + 16'h1, 16'h0001, "R9");
    feed(16'hBEEF, "R9");
    idle(3, "R9");
    svcGrant = 1; tick("R10"); svcGrant = 0;
    tick("R10");
    idle(3, "R11");
    rdBus(BASE, "R11");
    idle(2, "R11");
    feed(16'h7777, "R9");
    tick("R9");
    svcGrant = 1; tick("R10"); svcGrant = 0;
    rdBus(BASE + 16'h1, "R10");
    idle(1, "R11");
    rdBus(BASE, "R11");
    idle(1, "R11");
    // run dropped while asking
    feed(16'h3333, "R9");
    idle(2, "R9");
    wrBus(BASE + 16'h1, 16'h0000, "R9");
    idle(3, "R9");
    // function clear
    wrBus(BASE + 16'h1, 16'h00FF, "R7");
    devError = 1; tick("R7"); devError = 0;
    idle(1, "R7");
    wrBus(BASE + 16'h2, 16'hFFFF, "R7");
    rdBus(BASE + 16'h1, "R7");
    rdBus(BASE + 16'h2, "R7");
    rdBus(BASE, "R7");
    idle(1, "R7");
    // clear and error in same cycle
    busAddr = BASE + 16'h2; busWrData = 0; busWrEn = 1; devError = 1;
    tick("R6");
    busWrEn = 0; devError = 0;
    rdBus(BASE + 16'h2, "R6");
    wrBus(BASE + 16'h2, 16'h0, "R6");
    rdBus(BASE + 16'h2, "R6");
    // clear during request
    wrBus(BASE + 16'h1, 16'h0001, "R7");
    feed(16'h4444, "R7");
    idle(2, "R7");
    wrBus(BASE + 16'h2, 16'h0, "R7");
    idle(2, "R7");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule